// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers interrupt events from the peripherals of a small 4-bit controller core and turns them into one request line for the CPU. Each of eleven sources owns a latched event flag and an enable (mask) bit. The sources fall into seven vector groups: four clock-timer rates, two stopwatch rates, A/D done, the K0 input group, the K1 input, serial transfer done and the programmable timer. The request rises when at least one flag is set and unmasked and the global interrupt enable is on.

When the CPU acknowledges a pending request, the block latches the low four program-counter bits of the winning group's vector. The vector sits on page 1, at offsets 2, 4, ..., E. At the same moment the global enable turns off, so no further request reaches the CPU until software sets it again. Software reaches flags and masks through a 4-bit register port. Reading a flag register returns its flags and clears them.

Top module: `irqc_top`

## Requirements
- R1: A one-cycle pulse on `evt_i[k]` sets flag k at the next clock edge, whatever the value of mask k. Source index: 0 clock 32 Hz, 1 clock 8 Hz, 2 clock 2 Hz, 3 clock 1 Hz, 4 stopwatch 10 Hz, 5 stopwatch 1 Hz, 6 A/D, 7 K0 group, 8 K1, 9 serial, 10 programmable timer.
- R2: The flag registers are read-only. With `reg_sel_i`=1 and `reg_we_i`=0, `rdata_o` shows the addressed register in the same cycle, and the flags at a flag address clear at the next edge. Address 0 holds flags {3,2,1,0} in bits 3..0. Address 1 holds {5,4} in bits 1..0. Address 2 holds {10,9,8,7} in bits 3..0. Address 3 holds flag 6 in bit 0. Unused bits read 0.
- R3: After reset every flag, every mask, `gie_o`, `irq_o` and `vec_o` are 0.
- R4: `irq_o` is 1 exactly when `gie_o` is 1 and at least one flag is set together with its mask bit.
- R5: `ack_i` while `irq_o`=1 clears `gie_o` at the next edge, so `irq_o` drops. `ack_i` while `irq_o`=0 changes neither `gie_o` nor `vec_o`.
- R6: The vector of the highest pending group wins. The offsets are 2 clock timer, 4 stopwatch, 6 A/D, 8 K0 group, A K1, C serial and E programmable timer, and the priority rises in that order.
- R7: Any single unmasked flag of the clock-timer or stopwatch group requests that group's vector.
- R8: `vec_o` is loaded only on an accepted acknowledge and holds its value at all other times.
- R9: A set event in the same cycle as a read of that flag wins, so the flag stays 1.
- R10: `ei_i` sets `gie_o` and `di_i` clears it. An accepted acknowledge outranks `di_i`, which outranks `ei_i`.
- R11: Masks are read/write at addresses 4 to 7, with the same bit layout as addresses 0 to 3. Mask writes are accepted in any state and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 11 | One-cycle event strobes, one per source |
| reg_sel_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data (combinational, 0 when not selected) |
| ei_i | input | 1 | Set global enable |
| di_i | input | 1 | Clear global enable |
| ack_i | input | 1 | CPU acknowledge of the request |
| irq_o | output | 1 | Interrupt request to CPU |
| gie_o | output | 1 | Current global enable |
| vec_o | output | 4 | Low four vector bits of the last accepted interrupt |

## Verification
A flag stuck or lost inside the block shows up one cycle later. It appears either as a wrong `rdata_o` bit on the next read of that address or as `irq_o` rising or staying low after `ei_i`. A wrong group map or a wrong priority order gives a wrong `vec_o` on the cycle after the acknowledge. A global enable that fails to drop keeps `irq_o` high on that same cycle. The bench covers patterns with one and with several sources, partial masks, and simultaneous set and read.

// File: rtl/irqc_pkg.sv
// Package: shared sizes and source/group/address mapping for the controller.
// Assumes eleven sources in seven fixed groups; the map is computed, not tabled.
package irqc_pkg;
    localparam int DATA_W   = 4;
    localparam int ADDR_W   = 3;
    localparam int NUM_SRC  = 11;
    localparam int NUM_GRP  = 7;
    localparam int VEC_W    = 4;
    localparam int MASK_OFS = 4;

    // Register row (flag address) holding source i.
    function automatic int src_row(input int i);
        if (i < 4)       return 0;
        else if (i < 6)  return 1;
        else if (i == 6) return 3;
        else             return 2;
    endfunction

    // Bit position of source i within its row.
    function automatic int src_bit(input int i);
        if (i < 4)       return i;
        else if (i < 6)  return i - 4;
        else if (i == 6) return 0;
        else             return i - 7;
    endfunction

    // Vector group (1 lowest .. 7 highest priority) of source i.
    function automatic int src_grp(input int i);
        if (i < 4)      return 1;
        else if (i < 6) return 2;
        else            return i - 3;
    endfunction

    // Membership vector of group g.
    function automatic logic [NUM_SRC-1:0] grp_members(input int g);
        logic [NUM_SRC-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_grp(i) == g) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/irqc_flag_bank.sv
// Flag and mask storage with the register read/write port.
// Assumes one-cycle event strobes; a flag read clears it unless an event
// arrives in the same cycle. Read data is combinational on the access cycle.
module irqc_flag_bank
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               reg_sel_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] hit_f;
    logic [NUM_SRC-1:0] hit_m;
    logic [DATA_W-1:0]  rd_part [NUM_SRC];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int BIT = src_bit(i);
        localparam logic [ADDR_W-1:0] FADR = ADDR_W'(src_row(i));
        localparam logic [ADDR_W-1:0] MADR = ADDR_W'(src_row(i) + MASK_OFS);

        assign hit_f[i] = reg_sel_i && (reg_addr_i == FADR);
        assign hit_m[i] = reg_sel_i && (reg_addr_i == MADR);

        // Flag: event sets (and wins over), read access clears.
        always_ff @(posedge clk) begin
            if (!rst_n)                        flag_q[i] <= 1'b0;
            else if (evt_i[i])                 flag_q[i] <= 1'b1;
            else if (hit_f[i] && !reg_we_i)    flag_q[i] <= 1'b0;
        end

        // Mask: written from its bit of the write data.
        always_ff @(posedge clk) begin
            if (!rst_n)                        mask_q[i] <= 1'b0;
            else if (hit_m[i] && reg_we_i)     mask_q[i] <= reg_wdata_i[BIT];
        end

        // Read contribution of this source at its flag or mask address.
        always_comb begin
            rd_part[i] = '0;
            if (hit_f[i])      rd_part[i][BIT] = flag_q[i];
            else if (hit_m[i]) rd_part[i][BIT] = mask_q[i];
        end

        a_r1_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> flag_q[i]);
        a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_f[i] && !reg_we_i && !evt_i[i]) |=> !flag_q[i]);
        a_r11_write_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_sel_i && reg_we_i && !evt_i[i]) |=> (flag_q[i] == $past(flag_q[i])));
    end

    // Merge the per-source read contributions into one data word.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_SRC; i++) rdata_o = rdata_o | rd_part[i];
    end

    assign pend_o = flag_q & mask_q;
endmodule

// File: rtl/irqc_prio_enc.sv
// Group OR and fixed-priority encoder: highest pending group gives the vector.
// Assumes group g maps to even offset 2*g; purely combinational.
module irqc_prio_enc
    import irqc_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               any_o,
    output logic [VEC_W-1:0]   vec_o
);
    logic [NUM_GRP:1] grp_pend;

    for (genvar g = 1; g <= NUM_GRP; g++) begin : g_grp
        localparam logic [NUM_SRC-1:0] MEMB = grp_members(g);
        assign grp_pend[g] = |(pend_i & MEMB);
    end

    // Walk groups lowest to highest so the highest pending one lands last.
    always_comb begin
        vec_o = '0;
        for (int g = 1; g <= NUM_GRP; g++) begin
            if (grp_pend[g]) vec_o = VEC_W'(2 * g);
        end
    end

    assign any_o = |grp_pend;

    // Top group always wins; vector is always even.
    always_comb begin
        if (grp_pend[NUM_GRP]) a_r6_top_prio: assert (vec_o == VEC_W'(2 * NUM_GRP));
        a_r6_even: assert (vec_o[0] == 1'b0);
    end
endmodule

// File: rtl/irqc_gate.sv
// Global enable, request gating and vector latch.
// Assumes ack is only meaningful while the request is up; ack > di > ei.
module irqc_gate
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ei_i,
    input  logic             di_i,
    input  logic             ack_i,
    input  logic             any_i,
    input  logic [VEC_W-1:0] nxt_vec_i,
    output logic             irq_o,
    output logic             gie_o,
    output logic [VEC_W-1:0] vec_o
);
    logic gie_q;
    logic take;

    assign irq_o = gie_q && any_i;
    assign take  = ack_i && irq_o;

    // Global enable: accepted ack and di clear it, ei sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)     gie_q <= 1'b0;
        else if (take)  gie_q <= 1'b0;
        else if (di_i)  gie_q <= 1'b0;
        else if (ei_i)  gie_q <= 1'b1;
    end

    // Vector latch: loaded only when an interrupt is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)    vec_o <= '0;
        else if (take) vec_o <= nxt_vec_i;
    end

    assign gie_o = gie_q;

    a_r5_take_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> (!gie_o && !irq_o));
    a_r8_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_i && irq_o) |=> $stable(vec_o));
    a_r10_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
        di_i |=> !gie_o);
endmodule

// File: rtl/irqc_top.sv
// Top: prioritized maskable interrupt controller for a small 4-bit core.
// Assumes event strobes are synchronous one-cycle pulses from peripherals.
module irqc_top
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               reg_sel_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic               ei_i,
    input  logic               di_i,
    input  logic               ack_i,
    output logic               irq_o,
    output logic               gie_o,
    output logic [VEC_W-1:0]   vec_o
);
    logic [NUM_SRC-1:0] pend;
    logic               any_pend;
    logic [VEC_W-1:0]   nxt_vec;

    irqc_flag_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .reg_sel_i  (reg_sel_i),
        .reg_we_i   (reg_we_i),
        .reg_addr_i (reg_addr_i),
        .reg_wdata_i(reg_wdata_i),
        .rdata_o    (rdata_o),
        .pend_o     (pend)
    );

    irqc_prio_enc u_prio (
        .pend_i (pend),
        .any_o  (any_pend),
        .vec_o  (nxt_vec)
    );

    irqc_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .ei_i     (ei_i),
        .di_i     (di_i),
        .ack_i    (ack_i),
        .any_i    (any_pend),
        .nxt_vec_i(nxt_vec),
        .irq_o    (irq_o),
        .gie_o    (gie_o),
        .vec_o    (vec_o)
    );

    a_r4_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> gie_o);
endmodule

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] evt = '0;
    logic        sel = 1'b0, we = 1'b0;
    logic [2:0]  addr = '0;
    logic [3:0]  wdata = '0;
    logic [3:0]  rdata;
    logic        ei = 1'b0, di = 1'b0, ack = 1'b0;
    logic        irq, gie;
    logic [3:0]  vec;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irqc_top i_irqc_top (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .reg_sel_i(sel), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .rdata_o(rdata),
        .ei_i(ei), .di_i(di), .ack_i(ack),
        .irq_o(irq), .gie_o(gie), .vec_o(vec)
    );

    typedef struct packed {
        logic [10:0] ev;
        logic [10:0] msk;
        logic        irq;
        logic [3:0]  vec;
    } row_t;

    localparam int NROW = 10;
    localparam row_t TBL [NROW] = '{
        '{ev:11'h008, msk:11'h7FF, irq:1'b1, vec:4'h2},
        '{ev:11'h010, msk:11'h7FF, irq:1'b1, vec:4'h4},
        '{ev:11'h0C0, msk:11'h7FF, irq:1'b1, vec:4'h8},
        '{ev:11'h7FF, msk:11'h7FF, irq:1'b1, vec:4'hE},
        '{ev:11'h7FF, msk:11'h3FF, irq:1'b1, vec:4'hC},
        '{ev:11'h001, msk:11'h001, irq:1'b1, vec:4'h2},
        '{ev:11'h200, msk:11'h5FF, irq:1'b0, vec:4'h0},
        '{ev:11'h102, msk:11'h7FF, irq:1'b1, vec:4'hA},
        '{ev:11'h040, msk:11'h040, irq:1'b1, vec:4'h6},
        '{ev:11'h420, msk:11'h030, irq:1'b1, vec:4'h4}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] d);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        tick();
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [3:0] d);
        sel = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        tick();
        sel = 1'b0;
    endtask

    task automatic set_masks(input logic [10:0] m);
        wr(3'd4, m[3:0]);
        wr(3'd5, {2'b00, m[5:4]});
        wr(3'd6, m[10:7]);
        wr(3'd7, {3'b000, m[6]});
    endtask

    task automatic pulse_evt(input logic [10:0] e);
        evt = e;
        tick();
        evt = '0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0]  d;
        logic [3:0]  last_vec;
        logic [10:0] e;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R3: reset state
        check("R3 irq", irq, 0);
        check("R3 gie", gie, 0);
        check("R3 vec", vec, 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R3 reg", d, 0);
        end

        // R11: mask write/read-back with layout of addresses 4..7
        set_masks(11'h5A5);
        rd(3'd4, d); check("R11 mask4", d, 4'h5);
        rd(3'd5, d); check("R11 mask5", d, 4'h2);
        rd(3'd6, d); check("R11 mask6", d, 4'hB);
        rd(3'd7, d); check("R11 mask7", d, 4'h0);

        // Table walk: R1 R2 R4 R5 R6 R7 R8 R10
        last_vec = 4'h0;
        for (int r = 0; r < NROW; r++) begin
            e = TBL[r].ev;
            check("R11 gie low before mask write", gie, 0);
            set_masks(TBL[r].msk);
            pulse_evt(e);
            check("R4 no irq while gie off", irq, 0);
            ei = 1'b1; tick(); ei = 1'b0;
            check("R10 ei sets gie", gie, 1);
            check("R4 R7 irq", irq, TBL[r].irq);
            ack = 1'b1; tick(); ack = 1'b0;
            if (TBL[r].irq) begin
                check("R6 vector", vec, TBL[r].vec);
                check("R5 gie cleared", gie, 0);
                check("R5 irq dropped", irq, 0);
                last_vec = TBL[r].vec;
            end else begin
                check("R8 vec held", vec, last_vec);
                check("R5 ignored ack keeps gie", gie, 1);
                di = 1'b1; tick(); di = 1'b0;
                check("R10 di clears gie", gie, 0);
            end
            rd(3'd0, d); check("R1 R2 row0", d, e[3:0]);
            rd(3'd1, d); check("R1 R2 row1", d, {2'b00, e[5:4]});
            rd(3'd2, d); check("R1 R2 row2", d, e[10:7]);
            rd(3'd3, d); check("R1 R2 row3", d, {3'b000, e[6]});
            rd(3'd0, d); check("R2 cleared row0", d, 0);
            rd(3'd2, d); check("R2 cleared row2", d, 0);
        end

        // R9: event in same cycle as read-clear wins
        pulse_evt(11'h040);
        sel = 1'b1; we = 1'b0; addr = 3'd3; evt = 11'h040;
        #1 d = rdata;
        tick();
        sel = 1'b0; evt = '0;
        check("R9 read shows flag", d, 4'h1);
        rd(3'd3, d); check("R9 flag survives", d, 4'h1);
        rd(3'd3, d); check("R2 then clears", d, 4'h0);

        // R10: accepted ack outranks ei in the same cycle
        set_masks(11'h7FF);
        pulse_evt(11'h400);
        ei = 1'b1; tick();
        ack = 1'b1; tick(); ack = 1'b0; ei = 1'b0;
        check("R10 ack beats ei", gie, 0);
        check("R8 vec after ack", vec, 4'hE);

        // R8: events while disabled leave vec unchanged
        pulse_evt(11'h001);
        ack = 1'b1; tick(); ack = 1'b0;
        check("R8 vec stable", vec, 4'hE);
        check("R4 irq low", irq, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule